// File: doc/BRIEF.md
# Difficulty-Weighted Score Accumulator

This block keeps a game's running score and drives the score onto a four-digit seven-segment display. Each new win event adds 10, 20 or 30 points. A two-bit difficulty input picks the amount. The total is stored as packed BCD digits, so it needs no binary-to-decimal conversion before display.

A free-running refresh divider steps a digit pointer. The pointer selects one digit at a time and drives that digit onto shared, registered, active-low segment lines while its own enable is pulled low. The win input is edge-qualified, so a level that stays high for many cycles scores only once. The total stops at the largest value the digits can show with a zero units digit.

Top module: `score_display_top`

## Requirements
- R1: While `rst` is high at a clock edge, the score is cleared to zero. Once the scan runs, every digit shows 0.
- R2: A win event with `level_sel` = 0 adds 10 to the score.
- R3: A win event with `level_sel` = 1 adds 20 to the score.
- R4: A win event with `level_sel` = 2 adds 30 to the score.
- R5: A win event with `level_sel` = 3 adds 30, the same as level 2.
- R6: Only a 0-to-1 transition of `win_in` between consecutive clock edges is a win event. Holding `win_in` high adds points once.
- R7: The score is held as decimal digits with the units digit fixed at 0. Carries ripple upward from the tens digit, so 90+20 gives 110 and 990+10 gives 1000.
- R8: An addition that would pass 9990 leaves the score at 9990. The score never decreases except through reset.
- R9: Exactly one bit of `dig_en_n` is low at any time after reset. Bit k shows the digit of weight 10^k. The low bit steps in the order 0,1,2,3,0,… and each bit stays low for REFRESH_DIV cycles.
- R10: `seg_n` is active low, with bit 0 = segment a through bit 6 = segment g. Digit 0 shows as 7'h40 and digit 8 shows as 7'h00. The patterns for 0 to 9 are the usual ones (1 lights b and c; 7 lights a, b and c).
- R11: A change of `level_sel` with no win event leaves the score unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_in | input | 1 | Win indication; its rising edge scores |
| level_sel | input | 2 | Difficulty code selecting +10/+20/+30 |
| seg_n | output | 7 | Active-low segments a..g of the enabled digit |
| dig_en_n | output | DIGITS | Active-low digit enables, bit k = 10^k digit |

## Verification
The assertions take for granted that `win_in` is a clean synchronous level. A win is assumed to be separated from the next one by at least one low cycle, because a rising edge only exists after a low sample. They also assume that `level_sel` is steady on the cycle of a win edge. The stimulus changes `win_in` and `level_sel` only on falling clock edges. It always drops `win_in` for a full cycle before the next win, and it reads the display only after the score has settled. This keeps each scanned digit tied to a single, stable total.

// File: rtl/score_disp_pkg.sv
package score_disp_pkg;

  typedef logic [3:0] bcd_t;

  // Difficulty code to tens-digit increment (1, 2 or 3 tens)
  function automatic logic [1:0] level_tens(input logic [1:0] lvl);
    logic [1:0] t;
    case (lvl)
      2'd0:    t = 2'd1;
      2'd1:    t = 2'd2;
      default: t = 2'd3;
    endcase
    return t;
  endfunction

  // BCD digit to active-low segments, bit0 = a .. bit6 = g
  function automatic logic [6:0] seg_lo(input bcd_t d);
    logic [6:0] on;
    case (d)
      4'd0:    on = 7'b0111111;
      4'd1:    on = 7'b0000110;
      4'd2:    on = 7'b1011011;
      4'd3:    on = 7'b1001111;
      4'd4:    on = 7'b1100110;
      4'd5:    on = 7'b1101101;
      4'd6:    on = 7'b1111101;
      4'd7:    on = 7'b0000111;
      4'd8:    on = 7'b1111111;
      4'd9:    on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/score_win_edge.sv
module score_win_edge (
  input  logic clk,
  input  logic win_in,
  output logic win_pulse
);
  logic win_prev;

  // Previous sample follows the input through reset too, so a level
  // already high when reset drops is not taken as a fresh edge.
  always_ff @(posedge clk) begin
    win_prev <= win_in;
  end

  assign win_pulse = win_in & ~win_prev;
endmodule

// File: rtl/score_bcd_digit.sv
module score_bcd_digit
  import score_disp_pkg::*;
(
  input  bcd_t       d_in,
  input  logic [1:0] c_in,
  output bcd_t       d_out,
  output logic       c_out
);
  logic [4:0] sum;

  always_comb begin
    sum = {1'b0, d_in} + {3'b000, c_in};
    if (sum >= 5'd10) begin
      d_out = 4'(sum - 5'd10);
      c_out = 1'b1;
    end else begin
      d_out = sum[3:0];
      c_out = 1'b0;
    end
  end
endmodule

// File: rtl/score_bcd_accum.sv
module score_bcd_accum
  import score_disp_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int HI_W = (DIGITS - 1) * 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                add_en,
  input  logic [1:0]          tens_inc,
  output logic [DIGITS*4-1:0] score_flat
);
  localparam logic [HI_W-1:0] SAT_HI = {(DIGITS-1){4'd9}};

  logic [HI_W-1:0] score_hi;
  logic [HI_W-1:0] next_hi;
  logic [1:0]      carry [1:DIGITS];

  assign carry[1] = tens_inc;

  for (genvar g = 1; g < DIGITS; g++) begin : g_digit
    logic c_o;
    score_bcd_digit u_digit (
      .d_in  (score_hi[(g-1)*4 +: 4]),
      .c_in  (carry[g]),
      .d_out (next_hi[(g-1)*4 +: 4]),
      .c_out (c_o)
    );
    assign carry[g+1] = {1'b0, c_o};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score_hi <= '0;
    end else if (add_en) begin
      if (carry[DIGITS] != 2'd0) score_hi <= SAT_HI;
      else                       score_hi <= next_hi;
    end
  end

  assign score_flat = {score_hi, 4'd0};
endmodule

// File: rtl/score_display_scan.sv
module score_display_scan
  import score_disp_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int REFRESH_DIV = 50000,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int CNT_W = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIGITS*4-1:0] score_flat,
  output logic [6:0]          seg_n,
  output logic [DIGITS-1:0]   dig_en_n,
  output logic                scan_tick,
  output logic [IDX_W-1:0]    scan_idx
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

  logic [CNT_W-1:0] div_cnt;
  bcd_t             cur_digit;

  assign scan_tick = (div_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst)            div_cnt <= '0;
    else if (scan_tick) div_cnt <= '0;
    else                div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_idx <= '0;
    end else if (scan_tick) begin
      if (scan_idx == IDX_LAST) scan_idx <= '0;
      else                      scan_idx <= scan_idx + 1'b1;
    end
  end

  assign cur_digit = score_flat[int'(scan_idx)*4 +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n    <= '1;
      dig_en_n <= '1;
    end else begin
      seg_n    <= seg_lo(cur_digit);
      dig_en_n <= ~(DIGITS'(1) << scan_idx);
    end
  end
endmodule

// File: rtl/score_display_top.sv
module score_display_top
  import score_disp_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int REFRESH_DIV = 50000,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_in,
  input  logic [1:0]        level_sel,
  output logic [6:0]        seg_n,
  output logic [DIGITS-1:0] dig_en_n
);
  logic                win_pulse;
  logic [DIGITS*4-1:0] score_flat;
  logic                scan_tick;
  logic [IDX_W-1:0]    scan_idx;

  score_win_edge u_edge (
    .clk       (clk),
    .win_in    (win_in),
    .win_pulse (win_pulse)
  );

  score_bcd_accum #(.DIGITS(DIGITS)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .add_en     (win_pulse),
    .tens_inc   (level_tens(level_sel)),
    .score_flat (score_flat)
  );

  score_display_scan #(.DIGITS(DIGITS), .REFRESH_DIV(REFRESH_DIV)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .score_flat (score_flat),
    .seg_n      (seg_n),
    .dig_en_n   (dig_en_n),
    .scan_tick  (scan_tick),
    .scan_idx   (scan_idx)
  );
endmodule

// File: rtl/score_display_chk.sv
module score_display_chk #(
  parameter int DIGITS = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                win_in,
  input logic [DIGITS-1:0]   dig_en_n,
  input logic [DIGITS*4-1:0] score_flat,
  input logic                win_pulse,
  input logic                scan_tick,
  input logic [IDX_W-1:0]    scan_idx
);
  localparam logic [DIGITS*4-1:0] SAT = {{(DIGITS-1){4'd9}}, 4'd0};

  // R9: at most one digit enabled
  a_r9_one_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_en_n)) else $error("R9 several digit enables low");

  // R9: pointer moves only on refresh tick
  a_r9_idx_holds: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(scan_idx)) else $error("R9 pointer moved without tick");

  // R6: a held win adds nothing
  a_r6_held_win: assert property (@(posedge clk) disable iff (rst)
    win_in && $past(win_in) |=> $stable(score_flat)) else $error("R6 held win scored");

  // R11: no edge, no change
  a_r11_no_event_stable: assert property (@(posedge clk) disable iff (rst)
    !win_pulse |=> $stable(score_flat)) else $error("R11 score moved without win");

  // R2: a win below the ceiling changes the score
  a_r2_win_adds: assert property (@(posedge clk) disable iff (rst)
    win_pulse && (score_flat != SAT) |=> !$stable(score_flat))
    else $error("R2 win did not change score");

  // R8: score never decreases
  a_r8_never_decreases: assert property (@(posedge clk) disable iff (rst)
    win_pulse |=> score_flat >= $past(score_flat)) else $error("R8 score decreased");

  // R7: every stored digit is decimal
  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    a_r7_digit_decimal: assert property (@(posedge clk) disable iff (rst)
      score_flat[g*4 +: 4] <= 4'd9) else $error("R7 digit out of range");
  end
endmodule

bind score_display_top score_display_chk #(.DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .win_in     (win_in),
  .dig_en_n   (dig_en_n),
  .score_flat (score_flat),
  .win_pulse  (win_pulse),
  .scan_tick  (scan_tick),
  .scan_idx   (scan_idx)
);

// File: tb/score_display_top_tb.sv
module score_display_top_tb;
  localparam int DIGITS = 4;
  localparam int DIV    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             win_in = 1'b0;
  logic [1:0]       level_sel = 2'd0;
  logic [6:0]       seg_n;
  logic [DIGITS-1:0] dig_en_n;

  int n_run = 0;
  int n_fail = 0;
  int model = 0;
  logic [6:0] last_zero_seg;

  always #5 clk = ~clk;

  score_display_top #(.DIGITS(DIGITS), .REFRESH_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .win_in(win_in), .level_sel(level_sel),
    .seg_n(seg_n), .dig_en_n(dig_en_n)
  );

  function automatic int seg_to_dec(input logic [6:0] s);
    case (s)
      7'h40: return 0;  7'h79: return 1;  7'h24: return 2;  7'h30: return 3;
      7'h19: return 4;  7'h12: return 5;  7'h02: return 6;  7'h78: return 7;
      7'h00: return 8;  7'h10: return 9;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scan the display and rebuild the shown number; -1 when unreadable
  task automatic read_display(output int value);
    int dig [DIGITS];
    bit seen [DIGITS];
    bit bad = 0;
    for (int i = 0; i < DIGITS; i++) begin dig[i] = 0; seen[i] = 0; end
    for (int c = 0; c < 2*DIGITS*DIV + 4; c++) begin
      @(negedge clk);
      if ($countones(~dig_en_n) == 1) begin
        for (int p = 0; p < DIGITS; p++) begin
          if (!dig_en_n[p]) begin
            dig[p] = seg_to_dec(seg_n);
            seen[p] = 1;
            if (dig[p] < 0) bad = 1;
            if (p == 0) last_zero_seg = seg_n;
          end
        end
      end else bad = 1;
    end
    value = 0;
    for (int p = DIGITS-1; p >= 0; p--) begin
      if (!seen[p]) bad = 1;
      value = value * 10 + dig[p];
    end
    if (bad) value = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; win_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = 0;
  endtask

  task automatic do_win(input logic [1:0] lvl, input int hold);
    @(negedge clk);
    level_sel = lvl;
    win_in = 1'b1;
    repeat (hold) @(negedge clk);
    win_in = 1'b0;
    model = model + ((lvl == 2'd0) ? 10 : (lvl == 2'd1) ? 20 : 30);
    if (model > 9990) model = 9990;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    read_display(v);
    check("R1 reset total", v, 0);
    check("R10 zero pattern", int'(last_zero_seg), 'h40);
  endtask

  task automatic t_levels();
    int v;
    do_win(2'd0, 1); read_display(v); check("R2 level0 +10", v, model);
    do_win(2'd1, 1); read_display(v); check("R3 level1 +20", v, model);
    do_win(2'd2, 1); read_display(v); check("R4 level2 +30", v, model);
    do_win(2'd3, 1); read_display(v); check("R5 level3 +30", v, model);
  endtask

  task automatic t_hold();
    int v;
    do_win(2'd0, 25);
    read_display(v);
    check("R6 held win once", v, 100);
  endtask

  task automatic t_no_win();
    int v;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); level_sel = 2'(k);
    end
    read_display(v);
    check("R11 level change only", v, model);
  endtask

  task automatic t_ripple();
    int v;
    do_reset();
    for (int k = 0; k < 3; k++) do_win(2'd2, 1);
    do_win(2'd1, 1);
    read_display(v); check("R7 90+20", v, 110);
    for (int k = 0; k < 29; k++) do_win(2'd2, 1);
    do_win(2'd0, 1);
    read_display(v); check("R7 reach 990", v, 990);
    do_win(2'd0, 1);
    read_display(v); check("R7 990+10", v, 1000);
  endtask

  task automatic t_saturate();
    int v;
    do_reset();
    for (int k = 0; k < 332; k++) do_win(2'd2, 1);
    do_win(2'd1, 1);
    read_display(v); check("R8 reach 9980", v, 9980);
    do_win(2'd2, 1);
    read_display(v); check("R8 clamp 9980+30", v, 9990);
    do_win(2'd0, 1);
    read_display(v); check("R8 stay at 9990", v, 9990);
  endtask

  task automatic t_scan();
    int errs = 0;
    int run = 0;
    int prev_pos = -1;
    int runs_seen = 0;
    logic [DIGITS-1:0] prev_en;
    @(negedge clk);
    prev_en = dig_en_n;
    for (int c = 0; c < 20*DIV; c++) begin
      @(negedge clk);
      if ($countones(~dig_en_n) != 1) errs++;
      run++;
      if (dig_en_n != prev_en) begin
        int pos = 0;
        for (int p = 0; p < DIGITS; p++) if (!dig_en_n[p]) pos = p;
        if (prev_pos >= 0 && pos != (prev_pos + 1) % DIGITS) errs++;
        if (runs_seen > 0 && run != DIV) errs++;
        runs_seen++;
        prev_pos = pos;
        run = 0;
        prev_en = dig_en_n;
      end
    end
    check("R9 scan order and dwell", errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_levels();
    t_hold();
    t_no_win();
    t_scan();
    t_ripple();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule